// File: doc/BRIEF.md
# Parallel SAD Stereo Disparity Engine

The engine accepts two rectified 8-bit grayscale pixel streams, one from each camera, that advance together at one pixel per clock in raster order. It keeps the two most recent lines of each image in line stores. From those and the incoming pixel it builds 3x3 neighbourhoods and scores every candidate horizontal shift at once. There is one absolute-difference scoring unit per shift. A registered binary minimum tree then reduces all scores to the index of the cheapest shift. That index is the 8-bit disparity, and a new one leaves the engine on every clock that a pixel entered.

The result stream has the same number of pixels as the input stream and carries the frame and line markers along with it. Each result belongs to the pixel accepted a fixed number of cycles earlier. Its value describes the neighbourhood centred `NDISP` columns to the left of that pixel and one row above it. This anchoring lets every input pixel have a result with no look-ahead and no flush at the end of a frame. Positions whose neighbourhood or search range would leave the image return disparity 0 and still count as results. The line length limit `IMG_W` and the number of candidate shifts `NDISP` are parameters.

Top module: `stereo_sad_engine`

## Requirements
- R1: While reset is applied, and on every cycle that carries no result, out_valid, out_sof and out_eol are low and out_disp is 0.
- R2: Each cycle with in_valid high produces exactly one result, shown with out_valid high exactly $clog2(NDISP)+3 clock cycles later. out_valid is high on no other cycle.
- R3: out_sof and out_eol repeat the in_sof and in_eol of the same accepted pixel, with the same delay as in R2.
- R4: Positions count accepted pixels only. Column x is 0 on a pixel marked in_sof and on the pixel after one marked in_eol; otherwise it is one more than the previous column. Row y is 0 on the pixel marked in_sof and rises by one after each in_eol. For an interior position the result is the shift d in 0..NDISP-1 that minimises the sum over i,j in {-1,0,1} of |L(c+i, r+j) - R(c+d+i, r+j)|, with c = x-NDISP and r = y-1. Here L and R are the left and right intensities indexed (column, row).
- R5: When several shifts share the lowest sum, the smallest shift is reported.
- R6: A position with y < 2 or x < NDISP+1 is a border position. It yields disparity 0 with out_valid still high.
- R7: Cycles with in_valid low change neither the line stores, nor the column history, nor the position counters. Results with idle gaps between pixels equal the gap-free results.
- R8: Lines of any length up to IMG_W pixels are handled, including lines as long as IMG_W. Each image keeps exactly its two previous lines.
- R9: out_disp is always below NDISP, also when NDISP is not a power of two and the minimum tree holds padding entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel pair is present this cycle |
| in_sof | input | 1 | The pixel pair is the first of a frame |
| in_eol | input | 1 | The pixel pair is the last of its line |
| in_left | input | 8 | Left image intensity |
| in_right | input | 8 | Right image intensity |
| out_valid | output | 1 | A disparity result is present |
| out_sof | output | 1 | The result belongs to the first pixel of a frame |
| out_eol | output | 1 | The result belongs to the last pixel of a line |
| out_disp | output | 8 | Winning shift index, 0 at border positions |

## Verification
The hardest case to reach from the ports is a real tie between distant shifts inside the image. Random 8-bit pictures almost never give two equal minimum sums, so the lowest-index rule would stay untested. The stimulus builds a picture with a period of two columns and offsets the right image by one column, which gives zero cost at shifts 1, 3 and 5. It also sends a flat picture and binary-valued random pictures. Idle gaps of random length between pixels are mixed in, so the history registers must hold their contents while windows near the right edge of a line are being scored.

// File: rtl/stereo_sad_pkg.sv
package stereo_sad_pkg;

  localparam int PIX_W  = 8;
  localparam int COST_W = 12;   // 9 * 255 = 2295 fits, all-ones marks padding
  localparam int IDX_W  = 8;

  typedef logic [PIX_W-1:0]       pix_t;
  // one window column: [2] = current row, [1] = row above, [0] = two rows above
  typedef logic [2:0][PIX_W-1:0]  col_t;
  typedef logic [COST_W-1:0]      cost_t;

  typedef struct packed {
    cost_t            cost;
    logic [IDX_W-1:0] idx;
  } cand_t;

  function automatic cost_t abs_diff(pix_t a, pix_t b);
    return (a > b) ? cost_t'(a - b) : cost_t'(b - a);
  endfunction

  function automatic cost_t col_cost(col_t a, col_t b);
    cost_t s;
    s = '0;
    for (int r = 0; r < 3; r++) s = s + abs_diff(a[r], b[r]);
    return s;
  endfunction

  // 3x3 cost: three column sums added in a small tree
  function automatic cost_t win_cost(col_t [2:0] lw, col_t [2:0] rw);
    return col_cost(lw[0], rw[0]) + col_cost(lw[1], rw[1]) + col_cost(lw[2], rw[2]);
  endfunction

  // strict compare: on equal cost the left operand (lower index) survives
  function automatic cand_t pick_min(cand_t a, cand_t b);
    return (b.cost < a.cost) ? b : a;
  endfunction

endpackage

// File: rtl/stereo_linebuf.sv
module stereo_linebuf
  import stereo_sad_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int AW    = $clog2(IMG_W)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] col_idx,
  input  pix_t          pix,
  output col_t          col
);

  pix_t line_a [IMG_W];   // previous line
  pix_t line_b [IMG_W];   // line before that

  always_ff @(posedge clk) begin
    if (en) begin
      line_a[col_idx] <= pix;
      line_b[col_idx] <= line_a[col_idx];
    end
  end

  assign col = {pix, line_a[col_idx], line_b[col_idx]};

endmodule

// File: rtl/stereo_colhist.sv
module stereo_colhist
  import stereo_sad_pkg::*;
#(
  parameter int DEPTH  = 34,
  parameter int OUT_LO = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  col_t                      din,
  output col_t [DEPTH-OUT_LO-1:0]   taps
);

  // sh[0] is the newest column, sh[k] is k accepted pixels older
  col_t [DEPTH-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sh <= '0;
    else if (en) sh <= {sh[DEPTH-2:0], din};
  end

  assign taps = sh[DEPTH-1:OUT_LO];

endmodule

// File: rtl/stereo_sad_pe.sv
module stereo_sad_pe
  import stereo_sad_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  col_t [2:0] l_win,
  input  col_t [2:0] r_win,
  output cost_t      cost
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cost <= '0;
    else        cost <= win_cost(l_win, r_win);
  end

endmodule

// File: rtl/stereo_argmin.sv
module stereo_argmin
  import stereo_sad_pkg::*;
#(
  parameter int N = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cost_t [N-1:0]   costs,
  output cand_t           best
);

  localparam int LEVELS = $clog2(N);
  localparam int P      = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int M = P >> l;
    cand_t [M-1:0] node;
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < M; i++) begin : g_in
        if (i < N) begin : g_real
          assign node[i] = '{cost: costs[i], idx: IDX_W'(i)};
        end else begin : g_pad
          assign node[i] = '{cost: '1, idx: IDX_W'(i)};
        end
      end
    end else begin : g_node
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) node <= '0;
        else
          for (int i = 0; i < M; i++)
            node[i] <= pick_min(g_lvl[l-1].node[2*i], g_lvl[l-1].node[2*i+1]);
      end
    end
  end

  assign best = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/stereo_sad_engine.sv
module stereo_sad_engine
  import stereo_sad_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int NDISP = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eol,
  input  logic [7:0] in_left,
  input  logic [7:0] in_right,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eol,
  output logic [7:0] out_disp
);

  localparam int AW     = $clog2(IMG_W);
  localparam int LEVELS = $clog2(NDISP);
  localparam int HIST   = NDISP + 2;
  localparam int SB_LEN = LEVELS + 2;   // history stage + cost stage + tree levels

  typedef struct packed {
    logic vld;
    logic sof;
    logic eol;
    logic ok;
  } side_t;

  // ---------------- position tracking ----------------
  logic [AW-1:0] col_q, col_cur;
  logic [1:0]    row_q, row_cur;
  logic          pix_take;     // a pixel pair enters this cycle
  logic          win_ok;       // its window and search range lie inside the image

  assign pix_take = in_valid;
  assign col_cur  = in_sof ? '0 : col_q;
  assign row_cur  = in_sof ? '0 : row_q;
  assign win_ok   = (row_cur == 2'd2) && (32'(col_cur) >= NDISP + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_take) begin
      col_q <= in_eol ? '0 : col_cur + 1'b1;
      if (in_eol) row_q <= (row_cur == 2'd2) ? 2'd2 : row_cur + 2'd1;
      else        row_q <= row_cur;
    end
  end

  // ---------------- line stores ----------------
  col_t lcol, rcol;

  stereo_linebuf #(.IMG_W(IMG_W), .AW(AW)) u_lb_left (
    .clk(clk), .en(pix_take), .col_idx(col_cur), .pix(in_left), .col(lcol)
  );
  stereo_linebuf #(.IMG_W(IMG_W), .AW(AW)) u_lb_right (
    .clk(clk), .en(pix_take), .col_idx(col_cur), .pix(in_right), .col(rcol)
  );

  // ---------------- column histories ----------------
  col_t [2:0]      lwin;    // left columns x-NDISP-1 .. x-NDISP+1
  col_t [HIST-1:0] rhist;   // right columns x-NDISP-1 .. x

  stereo_colhist #(.DEPTH(HIST), .OUT_LO(NDISP - 1)) u_hist_left (
    .clk(clk), .rst_n(rst_n), .en(pix_take), .din(lcol), .taps(lwin)
  );
  stereo_colhist #(.DEPTH(HIST), .OUT_LO(0)) u_hist_right (
    .clk(clk), .rst_n(rst_n), .en(pix_take), .din(rcol), .taps(rhist)
  );

  // ---------------- one scoring unit per shift ----------------
  cost_t [NDISP-1:0] costs;

  for (genvar d = 0; d < NDISP; d++) begin : g_pe
    stereo_sad_pe u_pe (
      .clk(clk), .rst_n(rst_n),
      .l_win(lwin),
      .r_win(rhist[NDISP-d+1 : NDISP-d-1]),
      .cost(costs[d])
    );
  end

  // ---------------- minimum tree ----------------
  cand_t win;

  stereo_argmin #(.N(NDISP)) u_argmin (
    .clk(clk), .rst_n(rst_n), .costs(costs), .best(win)
  );

  // ---------------- sideband alignment ----------------
  side_t sb [SB_LEN];
  logic  tree_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SB_LEN; k++) sb[k] <= '0;
    end else begin
      sb[0] <= '{vld: in_valid, sof: in_valid & in_sof, eol: in_valid & in_eol, ok: win_ok};
      for (int k = 1; k < SB_LEN; k++) sb[k] <= sb[k-1];
    end
  end

  assign tree_valid = sb[SB_LEN-1].vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_disp  <= '0;
    end else begin
      out_valid <= tree_valid;
      out_sof   <= sb[SB_LEN-1].sof;
      out_eol   <= sb[SB_LEN-1].eol;
      out_disp  <= (tree_valid && sb[SB_LEN-1].ok) ? win.idx : '0;
    end
  end

endmodule

// File: rtl/stereo_sad_chk.sv
module stereo_sad_chk
  import stereo_sad_pkg::*;
#(
  parameter int NDISP = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic       in_eol,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_eol,
  input logic [7:0] out_disp,
  input logic       tree_valid,
  input cand_t      tree_win
);

  localparam int LAT = $clog2(NDISP) + 3;

  logic [LAT-1:0] v_sh, s_sh, e_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_sh <= '0;
      s_sh <= '0;
      e_sh <= '0;
    end else begin
      v_sh <= {v_sh[LAT-2:0], in_valid};
      s_sh <= {s_sh[LAT-2:0], in_valid & in_sof};
      e_sh <= {e_sh[LAT-2:0], in_valid & in_eol};
    end
  end

  // position of each result, rebuilt from the output markers
  int         ocol_q, ocol_cur;
  logic [1:0] orow_q, orow_cur;

  assign ocol_cur = out_sof ? 0 : ocol_q;
  assign orow_cur = out_sof ? 2'd0 : orow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocol_q <= 0;
      orow_q <= '0;
    end else if (out_valid) begin
      ocol_q <= out_eol ? 0 : ocol_cur + 1;
      if (out_eol) orow_q <= (orow_cur == 2'd2) ? 2'd2 : orow_cur + 2'd1;
      else         orow_q <= orow_cur;
    end
  end

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_disp == 8'd0) && !out_sof && !out_eol);

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_sh[LAT-1]);

  p_marker_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof == s_sh[LAT-1]) && (out_eol == e_sh[LAT-1]));

  p_border_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ((orow_cur != 2'd2) || (ocol_cur < NDISP + 1)) |-> out_disp == 8'd0);

  p_disp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_disp) < NDISP);

  p_pad_lose_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tree_valid |-> (32'(tree_win.idx) < NDISP) && (tree_win.cost != '1));

endmodule

bind stereo_sad_engine stereo_sad_chk #(.NDISP(NDISP)) u_sad_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
  .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_disp(out_disp),
  .tree_valid(tree_valid), .tree_win(win)
);

// File: tb/test_stereo_sad_engine.sv
module test_stereo_sad_engine;

  localparam int BW  = 20;
  localparam int BD  = 6;
  localparam int BH  = 6;
  localparam int LAT = $clog2(BD) + 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0] in_left = '0, in_right = '0;
  logic       out_valid, out_sof, out_eol;
  logic [7:0] out_disp;

  always #5 clk = ~clk;

  stereo_sad_engine #(.IMG_W(BW), .NDISP(BD)) i_stereo_sad_engine (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_left(in_left), .in_right(in_right),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_disp(out_disp)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int lf [BH][BW];
  int rf [BH][BW];

  int    q_disp [$];
  int    q_mark [$];
  int    q_cyc  [$];
  string q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // brute-force reference: scan all shifts, keep the first strictly lower cost
  function automatic int model(int x, int y);
    int cx, cy, best, bd, s, a, b;
    if (y < 2 || x < BD + 1) return 0;
    cx = x - BD;
    cy = y - 1;
    best = 32'h7fffffff;
    bd = 0;
    for (int d = 0; d < BD; d++) begin
      s = 0;
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++) begin
          a = lf[cy+dy][cx+dx];
          b = rf[cy+dy][cx+d+dx];
          s += (a > b) ? a - b : b - a;
        end
      if (s < best) begin
        best = s;
        bd = d;
      end
    end
    return bd;
  endfunction

  task automatic send_frame(int width, string tag, int gap_max);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < width; x++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (x == 0 && y == 0);
        in_eol   = (x == width - 1);
        in_left  = 8'(lf[y][x]);
        in_right = 8'(rf[y][x]);
        q_disp.push_back(model(x, y));
        q_mark.push_back({30'd0, in_sof, in_eol});
        q_cyc.push_back(cyc);
        q_tag.push_back((y < 2 || x < BD + 1) ? "R6" : tag);
        if (gap_max > 0) begin
          int g;
          g = int'($urandom % (gap_max + 1));
          repeat (g) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof = 1'b0;
            in_eol = 1'b0;
            in_left = 8'($urandom);   // junk on idle cycles (R7)
            in_right = 8'($urandom);
          end
        end
      end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_eol = 1'b0;
  endtask

  task automatic fill_random(int maxv);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        lf[y][x] = int'($urandom % (maxv + 1));
        rf[y][x] = int'($urandom % (maxv + 1));
      end
  endtask

  task automatic fill_shift(int k);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) lf[y][x] = int'($urandom % 256);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++)
        rf[y][x] = (x >= k) ? lf[y][x-k] : int'($urandom % 256);
  endtask

  // period-two picture, right offset by one column: zero cost at shifts 1, 3, 5
  task automatic fill_periodic();
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        lf[y][x] = (x % 2) * 60 + y * 7;
        rf[y][x] = ((x + 1) % 2) * 60 + y * 7;
      end
  endtask

  task automatic fill_flat(int v);
    for (int y = 0; y < BH; y++)
      for (int x = 0; x < BW; x++) begin
        lf[y][x] = v;
        rf[y][x] = v;
      end
  endtask

  // output monitor, sampling on the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_disp.size() == 0) begin
        check(1'b0, "R2", "result without accepted pixel", 1, 0);
      end else begin
        int e_disp, e_mark, e_cyc;
        string tg;
        e_disp = q_disp.pop_front();
        e_mark = q_mark.pop_front();
        e_cyc  = q_cyc.pop_front();
        tg     = q_tag.pop_front();
        check(cyc - e_cyc == LAT, "R2", "result delay", cyc - e_cyc, LAT);
        check({out_sof, out_eol} == 2'(e_mark), "R3", "sof/eol markers",
              int'({out_sof, out_eol}), e_mark);
        check(int'(out_disp) == e_disp, tg, "disparity", int'(out_disp), e_disp);
        check(int'(out_disp) < BD, "R9", "disparity range", int'(out_disp), BD - 1);
      end
    end
  end

  initial begin
    void'($urandom(32'h1c3a_57e2));
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_disp == 8'd0, "R1", "out_disp in reset", int'(out_disp), 0);
    check({out_sof, out_eol} == 2'b00, "R1", "markers in reset", int'({out_sof, out_eol}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid idle after reset", int'(out_valid), 0);

    fill_random(255);  send_frame(BW, "R8", 0);      // full-length lines
    fill_shift(2);     send_frame(BW, "R4", 0);
    fill_shift(5);     send_frame(18, "R4", 0);
    fill_periodic();   send_frame(BW, "R5", 0);
    fill_flat(90);     send_frame(16, "R5", 1);
    fill_random(1);    send_frame(16, "R5", 1);
    fill_random(255);  send_frame(14, "R7", 3);
    fill_shift(3);     send_frame(BW, "R7", 2);
    for (int f = 0; f < 3; f++) begin
      fill_random((f == 1) ? 7 : 255);
      send_frame(BW - 2 * f, "R4", f);
    end

    repeat (LAT + 4) @(negedge clk);
    check(q_disp.size() == 0, "R2", "results still missing", q_disp.size(), 0);
    check(out_valid == 1'b0, "R1", "out_valid after drain", int'(out_valid), 0);
    check(out_disp == 8'd0, "R1", "out_disp after drain", int'(out_disp), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule